// File: doc/BRIEF.md
# Clock-Stop SPI Master

This block runs one SPI transfer per accepted word. The serial clock is gated: it stays low while the block is idle and toggles only while a word is being shifted. The bus uses idle-low clock polarity. Both ends sample on the rising edge of the serial clock and change their outputs after the falling edge. Inside the block the word frame is active high. It is inverted at the pin to give an active-low slave enable.

The caller offers a word through a valid/ready handshake. The transfer starts when `tx_valid` and `tx_ready` are both high in the same cycle. `tx_ready` stays low from that cycle until the transfer has finished. Because of that, a word offered while a transfer is running waits, and the running frame is not disturbed. The received word comes back on a one-cycle `rx_valid` pulse. That side has no back-pressure, so the caller must take `rx_data` when `rx_valid` is high or later: `rx_data` holds its value until the next pulse.

Timing comes from `bit_tick`, a strobe from an outside bit-clock generator. Each strobe marks one half bit period. The word length is given with each word and is clamped into the range 8 to 32. Bits are shifted most significant first.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, `cs_n`=1, `sclk`=0, `mosi_oe`=0, `tx_ready`=1 and `rx_valid`=0.
- R2: A word is accepted only when `tx_valid`&&`tx_ready`. `tx_ready` is 0 from the cycle after acceptance until the transfer ends. A `tx_valid` offered during a transfer changes neither that transfer nor anything after it.
- R3: The effective length is `tx_len` clamped to the range 8 to 32, sampled at acceptance. `sclk` makes exactly that many rising edges per transfer.
- R4: `mosi` carries the low effective-length bits of `tx_data`, MSB first. The first bit is on `mosi` in the first cycle that `cs_n` is low, before any clock edge. `mosi` changes only after falling edges of `sclk`.
- R5: `miso` is sampled at each rising edge of `sclk`. `rx_data` holds the received bits right-aligned, with zeros above the effective length.
- R6: `cs_n` falls at least one half bit period (one `bit_tick` interval) before the first rising edge of `sclk`. It rises exactly one half bit period after the last rising edge, together with the final falling edge.
- R7: `mosi_oe` is 1 exactly while `cs_n` is 0. The data line is released when the frame ends.
- R8: `rx_valid` is high for exactly one cycle, in the cycle where `cs_n` returns high. `rx_data` keeps its value until the next pulse.
- R9: `sclk` is low whenever the block is idle. It changes only in the cycle after a `bit_tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | Half-bit strobe from the bit-clock generator |
| tx_valid | input | 1 | A transmit word is offered |
| tx_ready | output | 1 | The block is idle and will accept a word |
| tx_data | input | MAX_W | Transmit word, right-aligned |
| tx_len | input | LW | Requested word length |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Gated serial clock, idle low |
| cs_n | output | 1 | Slave enable, active low |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for `mosi` |
| rx_valid | output | 1 | One-cycle done pulse |
| rx_data | output | MAX_W | Received word, right-aligned |

## Verification
The hardest case to reach is a new word offered on the handshake while a frame is in mid-shift. A block that wrongly accepted it would corrupt the running word or start a second frame. The bench raises `tx_valid` with different data several ticks into a transfer. It then checks that the captured word is unchanged and that `cs_n` stays high after the done pulse. Out-of-range lengths (0, 5, 40) are also driven, to reach both clamp limits, alongside random lengths and data.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LEAD = 2'd1,
    PH_LOW  = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int MAX_W = 32,
  localparam int LW = $clog2(MAX_W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          bit_tick,
  input  logic [LW-1:0] len,
  output logic          idle,
  output logic          sclk,
  output logic          frame,
  output logic          rise_evt,
  output logic          mid_fall,
  output logic          last_fall
);
  phase_t        phase;
  logic [LW-1:0] len_q;
  logic [LW-1:0] nbits;
  logic          fall_evt;

  assign idle      = (phase == PH_IDLE);
  assign rise_evt  = (phase == PH_LOW)  && bit_tick;
  assign fall_evt  = (phase == PH_HIGH) && bit_tick;
  assign last_fall = fall_evt && (nbits == len_q);
  assign mid_fall  = fall_evt && (nbits != len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sclk  <= 1'b0;
      frame <= 1'b0;
      nbits <= '0;
      len_q <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase <= PH_LEAD;
          frame <= 1'b1;
          nbits <= '0;
          len_q <= len;
        end
        PH_LEAD: if (bit_tick) phase <= PH_LOW;
        PH_LOW: if (bit_tick) begin
          sclk  <= 1'b1;
          nbits <= nbits + 1'b1;
          phase <= PH_HIGH;
        end
        PH_HIGH: if (bit_tick) begin
          sclk <= 1'b0;
          if (nbits == len_q) begin
            phase <= PH_IDLE;
            frame <= 1'b0;
          end else begin
            phase <= PH_LOW;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
  parameter int MAX_W = 32,
  localparam int LW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MAX_W-1:0] tx_word,
  input  logic [LW-1:0]    len,
  input  logic             rise_evt,
  input  logic             mid_fall,
  input  logic             miso,
  output logic             mosi_bit,
  output logic [MAX_W-1:0] rx_word
);
  localparam logic [LW-1:0] WIDTH_L = LW'(MAX_W);

  logic [MAX_W-1:0] tx_sr;
  logic [LW-1:0]    shamt;

  assign shamt    = WIDTH_L - len;
  assign mosi_bit = tx_sr[MAX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr   <= '0;
      rx_word <= '0;
    end else begin
      if (load) begin
        tx_sr   <= tx_word << shamt;
        rx_word <= '0;
      end else begin
        if (mid_fall) tx_sr   <= {tx_sr[MAX_W-2:0], 1'b0};
        if (rise_evt) rx_word <= {rx_word[MAX_W-2:0], miso};
      end
    end
  end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master #(
  parameter int MAX_W = 32,
  parameter int MIN_W = 8,
  localparam int LW = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [MAX_W-1:0] tx_data,
  input  logic [LW-1:0]    tx_len,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic             mosi_oe,
  output logic             rx_valid,
  output logic [MAX_W-1:0] rx_data
);
  localparam logic [LW-1:0] LO_L = LW'(MIN_W);
  localparam logic [LW-1:0] HI_L = LW'(MAX_W);

  logic             idle, frame, accept;
  logic             rise_evt, mid_fall, last_fall;
  logic [LW-1:0]    eff_len;
  logic [MAX_W-1:0] rx_word;

  always_comb begin
    if (tx_len < LO_L)      eff_len = LO_L;
    else if (tx_len > HI_L) eff_len = HI_L;
    else                    eff_len = tx_len;
  end

  assign tx_ready = idle;
  assign accept   = tx_valid && idle;
  assign cs_n     = ~frame;
  assign mosi_oe  = frame;

  spi_cs_seq #(.MAX_W(MAX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .bit_tick(bit_tick),
    .len(eff_len), .idle(idle), .sclk(sclk), .frame(frame),
    .rise_evt(rise_evt), .mid_fall(mid_fall), .last_fall(last_fall)
  );

  spi_cs_shift #(.MAX_W(MAX_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .tx_word(tx_data),
    .len(eff_len), .rise_evt(rise_evt), .mid_fall(mid_fall),
    .miso(miso), .mosi_bit(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= last_fall;
      if (last_fall) rx_data <= rx_word;
    end
  end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_ready,
  input logic sclk,
  input logic cs_n,
  input logic mosi_oe,
  input logic rx_valid
);
  // R9: the clock only runs inside an active frame
  assert_sclk_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
  // R9: the clock moves only after a tick
  assert_sclk_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> $past(bit_tick));
  // R8: the done pulse lasts one cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R8: the done pulse comes with the frame end
  assert_done_at_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $rose(cs_n));
  // R2: no handshake while a frame is open
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !tx_ready);
  // R6: the frame closes with the clock low and the line released (R7)
  assert_release_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (!sclk && !mosi_oe));
endmodule

bind spi_cs_master spi_cs_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_ready(tx_ready),
  .sclk(sclk), .cs_n(cs_n), .mosi_oe(mosi_oe), .rx_valid(rx_valid)
);

// File: tb/spi_cs_master_tb.sv
module spi_cs_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int MAX_W = 32;
  localparam int LW = 6;

  logic clk = 0, rst_n = 0, bit_tick = 0, tx_valid = 0, miso = 0;
  logic [MAX_W-1:0] tx_data = '0;
  logic [LW-1:0] tx_len = '0;
  logic tx_ready, sclk, cs_n, mosi, mosi_oe, rx_valid;
  logic [MAX_W-1:0] rx_data;

  int n_tests = 0, n_fail = 0;

  spi_cs_master u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tcnt = 0;
  always @(negedge clk) begin
    tcnt = (tcnt == DIV-1) ? 0 : tcnt + 1;
    bit_tick = (tcnt == DIV-1);
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int l);
    if (l < 8) return 8;
    if (l > 32) return 32;
    return l;
  endfunction

  function automatic logic [31:0] msk(input int l);
    return 32'((64'd1 << l) - 1);
  endfunction

  // slave model and edge monitor
  logic [31:0] s_word = '0;
  int s_len = 8, s_idx = 0;
  logic p_sclk = 0, p_cs = 1, p_mosi = 0;
  int rises = 0, since_cs = 0, since_rise = 0;
  logic [31:0] cap = '0;
  always @(negedge clk) if (rst_n) begin
    since_cs++; since_rise++;
    if (p_cs && !cs_n) begin
      rises = 0; cap = '0; since_cs = 0;
      s_idx = s_len - 1; miso = s_word[s_idx];
    end
    if (!p_sclk && sclk) begin
      if (rises == 0) check(since_cs >= DIV, "R6 lead", since_cs, DIV);
      check(!cs_n, "R9 sclk in frame", cs_n, 0);
      check(mosi == p_mosi, "R4 mosi stable at rise", mosi, p_mosi);
      cap = {cap[30:0], mosi};
      rises++; since_rise = 0;
    end
    if (p_sclk && !sclk && !cs_n) begin
      s_idx--; if (s_idx >= 0) miso = s_word[s_idx];
    end
    if (!p_cs && cs_n) begin
      check(since_rise == DIV, "R6 tail", since_rise, DIV);
      check(rx_valid, "R8 done with release", rx_valid, 1);
    end
    p_sclk = sclk; p_cs = cs_n; p_mosi = mosi;
  end

  task automatic run(input int len, input logic [31:0] data, input logic [31:0] sdat, input bit poke);
    int el = eff(len);
    int w = 0;
    logic [31:0] held;
    s_word = sdat & msk(el); s_len = el;
    @(negedge clk);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1; tx_data = data; tx_len = LW'(len);
    @(negedge clk);
    tx_valid = 0;
    check(!tx_ready, "R2 busy", tx_ready, 0);
    check(!cs_n && mosi_oe, "R7 frame open", {cs_n, mosi_oe}, 1);
    check(mosi == data[el-1], "R4 first bit early", mosi, data[el-1]);
    if (poke) begin
      repeat (3*DIV) @(negedge clk);
      tx_valid = 1; tx_data = ~data; tx_len = 6'd8;
      @(negedge clk);
      check(!tx_ready, "R2 ignore mid start", tx_ready, 0);
      tx_valid = 0;
    end
    while (!rx_valid && w < 4000) begin @(negedge clk); w++; end
    check(w < 4000, "watchdog", w, 0);
    check(rises == el, "R3 edge count", rises, el);
    check(cap == (data & msk(el)), "R4 mosi word", cap, data & msk(el));
    check(rx_data == (sdat & msk(el)), "R5 rx word", rx_data, sdat & msk(el));
    held = rx_data;
    @(negedge clk);
    check(!rx_valid, "R8 single pulse", rx_valid, 0);
    check(cs_n && !mosi_oe && !sclk, "R7 released", {cs_n, mosi_oe, sclk}, 4);
    repeat (2*DIV) @(negedge clk);
    check(cs_n && !sclk, "R2 no extra frame", {cs_n, sclk}, 2);
    check(rx_data == held, "R8 hold", rx_data, held);
  endtask

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    check(cs_n && !sclk && !mosi_oe && tx_ready && !rx_valid, "R1 reset",
          {cs_n, sclk, mosi_oe, tx_ready, rx_valid}, 5'b10010);
    rst_n = 1;
    run(8, 32'hA5, 32'h3C, 0);
    run(32, 32'hDEADBEEF, 32'h80000001, 0);
    run(5, 32'hFFFF_FF96, 32'h0000_00C3, 0);   // R3 low clamp
    run(0, 32'h0000_0001, 32'h0000_0080, 0);   // R3 low clamp
    run(40, 32'h1234_5678, 32'hCAFE_F00D, 0);  // R3 high clamp
    run(16, 32'h0000_BEEF, 32'h0000_1234, 1);  // R2 busy offer
    for (int i = 0; i < 15; i++)
      run(8 + ($urandom % 25), $urandom, $urandom, (i % 4) == 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule